// File: doc/BRIEF.md
# Filtered Readback Output FIFO

This block is the return path from a rendering pipeline to the host. Producers inside the pipeline offer one item at a time. Each item belongs to one of four categories (depth, stencil, color or sync) and carries a 9-bit tag and a 32-bit data value. A filter setting with two bits per category decides what enters a 32-bit-wide output FIFO for each item: the tag, the data, both, or nothing. The host watches a word count and pops words through a single read port.

The FIFO never drops anything. When there is not enough room for the words an item needs, the producer is held off until the host frees space. A sync item whose data has its top bit set is marked. When the host reads the marked word out, a sticky interrupt flag is raised, provided the interrupt is enabled. The host clears that flag by writing a one to it.

Top module: `rb_out_fifo`

## Requirements
- R1: `filter_i[2c+1:2c]` controls category c, with depth=0, stencil=1, color=2 and sync=3. Bit 2c enables the tag word and bit 2c+1 enables the data word. Only the field of the item's own category has any effect on that item.
- R2: When both bits are set, the tag word (the 9-bit tag zero-extended to 32 bits) is pushed in the cycle the item is accepted, and the data word is pushed in the next cycle. `item_ready_o` is low during that second cycle.
- R3: When both bits are clear, the item is accepted (`item_ready_o` high) and no word is written.
- R4: `level_o` gives the number of words stored. It never exceeds DEPTH.
- R5: `item_ready_o` is low while the free space is smaller than the number of words the item needs. A held item is accepted once space appears, and no word is lost or reordered.
- R6: A pulse on `rd_i` pops the oldest word. That word appears on `rd_data_o` one cycle later, and words leave in the order they were written.
- R7: A read while the FIFO is empty returns zero on `rd_data_o` and sets `underflow_o`. The flag stays set until `uflow_clr_i` is pulsed.
- R8: A sync item with `item_data_i[31]`=1 marks the last word it writes. If `irq_en_i` is high when that word is popped, `irq_o` goes high in the same cycle the word appears on `rd_data_o`. Otherwise the flag is not set.
- R9: `irq_o` is sticky and is cleared by pulsing `irq_clr_i`. A new set in the same cycle takes priority over the clear.
- R10: After reset the FIFO is empty, both flags are low and `item_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| filter_i | input | 8 | Two enable bits per category |
| irq_en_i | input | 1 | Sync interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for irq_o |
| uflow_clr_i | input | 1 | Clear strobe for underflow_o |
| item_valid_i | input | 1 | Producer item valid |
| item_ready_o | output | 1 | Item accepted this cycle when high with valid |
| item_cat_i | input | 2 | Item category |
| item_tag_i | input | 9 | Item tag |
| item_data_i | input | 32 | Item data |
| rd_i | input | 1 | Host pop strobe |
| rd_data_o | output | 32 | Popped word, one cycle after rd_i |
| level_o | output | clog2(DEPTH+1) | Words currently stored |
| irq_o | output | 1 | Sticky sync interrupt flag |
| underflow_o | output | 1 | Sticky empty-read flag |

## Verification
The bench uses a 4-word FIFO. Every category is combined with all four filter codes, while the other categories carry the opposite code. This shows that each item is decoded from its own field only, and it separates tag-only, data-only, pair and drop behaviour by both word count and word content. Fill-to-full runs with a held item cover stalls on one-word and two-word needs. These runs show whether a stall loses or reorders data and whether the reservation of two free entries is enforced. The interrupt runs vary the enable, the top data bit, the tag-only case and a clear in the same cycle as a set. Together they tell apart mark-on-write from mark-on-pop and set priority from clear priority.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int TAG_W  = 9;
  localparam int WORD_W = 32;
  localparam int NCAT   = 4;

  typedef enum logic [1:0] {
    CAT_DEPTH   = 2'd0,
    CAT_STENCIL = 2'd1,
    CAT_COLOR   = 2'd2,
    CAT_SYNC    = 2'd3
  } rb_cat_e;

  typedef struct packed {
    logic              mark;
    logic [WORD_W-1:0] word;
  } rb_entry_t;
endpackage

// File: rtl/rb_filter.sv
module rb_filter
  import rb_pkg::*;
(
  input  logic [2*NCAT-1:0] filter_i,
  input  logic [1:0]        cat_i,
  output logic              tag_en_o,
  output logic              data_en_o,
  output logic [1:0]        need_o
);
  logic [NCAT-1:0] tag_en, data_en;

  for (genvar g = 0; g < NCAT; g++) begin : g_cat
    assign tag_en[g]  = filter_i[2*g];
    assign data_en[g] = filter_i[2*g+1];
  end

  assign tag_en_o  = tag_en[cat_i];
  assign data_en_o = data_en[cat_i];
  assign need_o    = {1'b0, tag_en_o} + {1'b0, data_en_o};
endmodule

// File: rtl/rb_fifo.sv
module rb_fifo
  import rb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  rb_entry_t        push_entry_i,
  input  logic             pop_i,
  output rb_entry_t        head_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] free_o,
  output logic             empty_o,
  output logic             full_o
);
  rb_entry_t        mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= push_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr_q];
  assign count_o = count_q;
  assign free_o  = CNT_W'(DEPTH) - count_q;
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  a_r4_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r6_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rb_flags.sv
module rb_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_set_i,
  input  logic irq_clr_i,
  input  logic uflow_set_i,
  input  logic uflow_clr_i,
  output logic irq_o,
  output logic uflow_o
);
  logic irq_q, uflow_q;

  // set beats clear so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      if (irq_set_i)      irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      if (uflow_set_i)        uflow_q <= 1'b1;
      else if (uflow_clr_i)   uflow_q <= 1'b0;
    end
  end

  assign irq_o   = irq_q;
  assign uflow_o = uflow_q;

  a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !irq_set_i) |=> !irq_o);
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_o);
endmodule

// File: rtl/rb_out_fifo.sv
module rb_out_fifo
  import rb_pkg::*;
#(
  parameter int DEPTH = 16,  // >= 2 so a tag/data pair fits
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2*NCAT-1:0] filter_i,
  input  logic              irq_en_i,
  input  logic              irq_clr_i,
  input  logic              uflow_clr_i,
  input  logic              item_valid_i,
  output logic              item_ready_o,
  input  logic [1:0]        item_cat_i,
  input  logic [TAG_W-1:0]  item_tag_i,
  input  logic [WORD_W-1:0] item_data_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  level_o,
  output logic              irq_o,
  output logic              underflow_o
);
  logic             tag_en, data_en;
  logic [1:0]       need;
  logic             accept, mark_item, push, pop;
  rb_entry_t        push_entry, head;
  logic [CNT_W-1:0] count, free;
  logic             empty, full;
  logic             pend_q, pend_mark_q;
  logic [WORD_W-1:0] pend_word_q, rd_data_q;

  rb_filter u_filter (
    .filter_i  (filter_i),
    .cat_i     (item_cat_i),
    .tag_en_o  (tag_en),
    .data_en_o (data_en),
    .need_o    (need)
  );

  assign item_ready_o = !pend_q && (free >= CNT_W'(need));
  assign accept       = item_valid_i && item_ready_o;
  assign mark_item    = (rb_cat_e'(item_cat_i) == CAT_SYNC) && item_data_i[WORD_W-1];

  always_comb begin
    push       = 1'b0;
    push_entry = '0;
    if (pend_q) begin
      push            = 1'b1;
      push_entry.mark = pend_mark_q;
      push_entry.word = pend_word_q;
    end else if (accept && tag_en) begin
      push            = 1'b1;
      push_entry.mark = mark_item && !data_en;  // mark goes on last word
      push_entry.word = WORD_W'(item_tag_i);
    end else if (accept && data_en) begin
      push            = 1'b1;
      push_entry.mark = mark_item;
      push_entry.word = item_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_mark_q <= 1'b0;
      pend_word_q <= '0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
    end else if (accept && tag_en && data_en) begin
      pend_q      <= 1'b1;
      pend_mark_q <= mark_item;
      pend_word_q <= item_data_i;
    end
  end

  rb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_entry_i (push_entry),
    .pop_i        (pop),
    .head_o       (head),
    .count_o      (count),
    .free_o       (free),
    .empty_o      (empty),
    .full_o       (full)
  );

  assign pop = rd_i && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_q <= '0;
    else if (pop)  rd_data_q <= head.word;
    else if (rd_i) rd_data_q <= '0;
  end

  rb_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_set_i   (pop && head.mark && irq_en_i),
    .irq_clr_i   (irq_clr_i),
    .uflow_set_i (rd_i && empty),
    .uflow_clr_i (uflow_clr_i),
    .irq_o       (irq_o),
    .uflow_o     (underflow_o)
  );

  assign rd_data_o = rd_data_q;
  assign level_o   = count;

  a_r2_pair_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && tag_en && data_en) |=> !item_ready_o);
  a_r3_drop_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !tag_en && !data_en) |=> level_o <= $past(level_o));
  a_r7_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && level_o == '0) |=> (rd_data_o == '0 && underflow_o));
  a_r8_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i && rd_i));
  a_r5_stall_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (item_valid_i && !pend_q && full && need != 2'd0) |-> !item_ready_o);
endmodule

// File: tb/rb_out_fifo_bench.sv
module rb_out_fifo_bench;
  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  filter_i = '0;
  logic irq_en_i = 0, irq_clr_i = 0, uflow_clr_i = 0;
  logic item_valid_i = 0, rd_i = 0;
  logic item_ready_o, irq_o, underflow_o;
  logic [1:0]  item_cat_i = '0;
  logic [8:0]  item_tag_i = '0;
  logic [31:0] item_data_i = '0, rd_data_o;
  logic [CNT_W-1:0] level_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  rb_out_fifo #(.DEPTH(DEPTH)) u_rb_out_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .filter_i(filter_i), .irq_en_i(irq_en_i),
    .irq_clr_i(irq_clr_i), .uflow_clr_i(uflow_clr_i), .item_valid_i(item_valid_i),
    .item_ready_o(item_ready_o), .item_cat_i(item_cat_i), .item_tag_i(item_tag_i),
    .item_data_i(item_data_i), .rd_i(rd_i), .rd_data_o(rd_data_o), .level_o(level_o),
    .irq_o(irq_o), .underflow_o(underflow_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] cat, input logic [8:0] tag, input logic [31:0] data);
    item_cat_i = cat; item_tag_i = tag; item_data_i = data; item_valid_i = 1;
    while (!item_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    item_valid_i = 0;
  endtask

  task automatic rd_word(output logic [31:0] w);
    rd_i = 1;
    @(negedge clk_i);
    rd_i = 0;
    w = rd_data_o;
  endtask

  task automatic expect_word(input logic [31:0] exp, input string req);
    logic [31:0] w;
    rd_word(w);
    chk(w == exp, req, w, exp);
  endtask

  task automatic pulse_rd_only;
    rd_i = 1; @(negedge clk_i); rd_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  f;
    logic [8:0]  tg;
    logic [31:0] dt;
    int n;

    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R10 reset state
    chk(level_o == 0, "R10 level", 32'(level_o), 0);
    chk(item_ready_o == 1, "R10 ready", 32'(item_ready_o), 1);
    chk(irq_o == 0 && underflow_o == 0, "R10 flags", {irq_o, underflow_o}, 0);

    // R1 R2 R3 sweep: own code on item category, opposite code elsewhere
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 4; m++) begin
        f = '0;
        for (int k = 0; k < 4; k++) f[2*k +: 2] = (k == c) ? 2'(m) : 2'(3 - m);
        filter_i = f;
        tg = 9'(9'h100 | (c << 4) | m);
        dt = 32'h1234_0000 | 32'(c << 8) | 32'(m);
        send(2'(c), tg, dt);
        @(negedge clk_i);
        n = (m & 1) + (m >> 1);
        chk(32'(level_o) == n, (m == 0) ? "R3 no word written" : "R1 word count", 32'(level_o), n);
        if (m[0]) expect_word(32'(tg), "R1 tag word");
        if (m[1]) expect_word(dt, (m == 3) ? "R2 data after tag" : "R1 data word");
        chk(level_o == 0, "R4 drained", 32'(level_o), 0);
      end
    end

    // R2 back-to-back timing
    filter_i = 8'h03;
    send(2'd0, 9'h1AB, 32'hDEAD_0001);
    chk(level_o == 1, "R2 tag pushed first cycle", 32'(level_o), 1);
    chk(item_ready_o == 0, "R2 ready low second cycle", 32'(item_ready_o), 0);
    @(negedge clk_i);
    chk(level_o == 2, "R2 data pushed next cycle", 32'(level_o), 2);
    chk(item_ready_o == 1, "R2 ready back", 32'(item_ready_o), 1);
    expect_word(32'h0000_01AB, "R2 tag zero-extended");
    expect_word(32'hDEAD_0001, "R2 data second");

    // R5 back-pressure on single-word items
    filter_i = 8'hAA;
    for (int i = 0; i < 4; i++) send(2'd0, 9'h0, 32'hB0 + 32'(i));
    chk(level_o == 4, "R4 full level", 32'(level_o), 4);
    item_cat_i = 2'd0; item_data_i = 32'hB4; item_valid_i = 1;
    repeat (3) @(negedge clk_i);
    chk(item_ready_o == 0, "R5 stall when full", 32'(item_ready_o), 0);
    chk(level_o == 4, "R4 level holds at DEPTH", 32'(level_o), 4);
    rd_i = 1; @(negedge clk_i); rd_i = 0;
    chk(rd_data_o == 32'hB0, "R6 first out", rd_data_o, 32'hB0);
    chk(item_ready_o == 1, "R5 ready after pop", 32'(item_ready_o), 1);
    @(negedge clk_i);
    item_valid_i = 0;
    chk(level_o == 4, "R5 held item accepted", 32'(level_o), 4);
    for (int i = 1; i < 5; i++) expect_word(32'hB0 + 32'(i), "R6 order kept through stall");

    // R5 pair needs two free entries
    for (int i = 0; i < 3; i++) send(2'd0, 9'h0, 32'hC0 + 32'(i));
    filter_i = 8'hAB;
    item_cat_i = 2'd0; item_tag_i = 9'h055; item_data_i = 32'hC3; item_valid_i = 1;
    @(negedge clk_i);
    chk(item_ready_o == 0, "R5 pair stalls with one free", 32'(item_ready_o), 0);
    rd_i = 1; @(negedge clk_i); rd_i = 0;
    chk(rd_data_o == 32'hC0, "R6 pop during stall", rd_data_o, 32'hC0);
    @(negedge clk_i);
    item_valid_i = 0;
    @(negedge clk_i);
    chk(level_o == 4, "R5 pair pushed after space", 32'(level_o), 4);
    expect_word(32'hC1, "R5 order");
    expect_word(32'hC2, "R5 order");
    expect_word(32'h055, "R5 pair tag");
    expect_word(32'hC3, "R5 pair data");

    // R7 empty read
    expect_word(32'h0, "R7 empty read zero");
    chk(underflow_o == 1, "R7 underflow set", 32'(underflow_o), 1);
    @(negedge clk_i);
    chk(underflow_o == 1, "R7 underflow sticky", 32'(underflow_o), 1);
    uflow_clr_i = 1; @(negedge clk_i); uflow_clr_i = 0;
    chk(underflow_o == 0, "R7 underflow cleared", 32'(underflow_o), 0);

    // R8 sync interrupt on pop of marked word
    irq_en_i = 1; filter_i = 8'h80;
    send(2'd3, 9'h0, 32'h8000_00AA);
    @(negedge clk_i);
    chk(irq_o == 0, "R8 no irq before pop", 32'(irq_o), 0);
    expect_word(32'h8000_00AA, "R8 sync data");
    chk(irq_o == 1, "R8 irq with data out", 32'(irq_o), 1);
    @(negedge clk_i);
    chk(irq_o == 1, "R9 irq sticky", 32'(irq_o), 1);
    irq_clr_i = 1; @(negedge clk_i); irq_clr_i = 0;
    chk(irq_o == 0, "R9 w1c clears", 32'(irq_o), 0);
    irq_en_i = 0;
    send(2'd3, 9'h0, 32'h8000_00BB);
    expect_word(32'h8000_00BB, "R8 data");
    chk(irq_o == 0, "R8 disabled no irq", 32'(irq_o), 0);
    irq_en_i = 1;
    send(2'd3, 9'h0, 32'h0000_00CC);
    expect_word(32'h0000_00CC, "R8 data");
    chk(irq_o == 0, "R8 msb clear no irq", 32'(irq_o), 0);
    filter_i = 8'h2A;  // sync dropped, others data
    send(2'd3, 9'h0, 32'h8000_00DD);
    chk(level_o == 0 && irq_o == 0, "R3 dropped sync writes nothing", {level_o, irq_o}, 0);
    filter_i = 8'h40;
    send(2'd3, 9'h077, 32'h8000_0000);
    rd_i = 1; irq_clr_i = 1; @(negedge clk_i); rd_i = 0; irq_clr_i = 0;
    chk(rd_data_o == 32'h077, "R8 tag-only word", rd_data_o, 32'h077);
    chk(irq_o == 1, "R9 set wins over clear", 32'(irq_o), 1);
    irq_clr_i = 1; @(negedge clk_i); irq_clr_i = 0;
    chk(irq_o == 0, "R9 cleared", 32'(irq_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule